// File: doc/BRIEF.md
# Flash Operation Command Sequencer

This block sits between a software-visible command register and the word-level request port of a flash memory controller. Software first loads a byte start address and then writes a command word carrying a start bit, the operation kind, program and erase sub-types, a partition select and a word count. When the start bit is accepted, the block aligns the address to the granularity the operation needs. It then walks a small state machine that issues one downstream request per word, or a single request for an erase, and reports completion through sticky done and error flags.

While an operation runs, the block refuses any further command write, so the parameters of the running operation cannot change under it. Program sub-types have enable bits that software can only clear. An erase-suspend request is held only while an erase is actually in progress. The access-permission verdict for each word is computed elsewhere and arrives as an input together with the downstream acknowledge.

Top module: `flash_cmd_seq`

## Requirements
- R1: Command word fields: bit 0 is start, bits 5:4 are the operation (0 read, 1 program, 2 erase), bit 6 selects repair programming, bit 7 selects bank erase and bit 8 selects the info partition. The latched operation and sub-type bits appear on `req_op_o`, `req_repair_o`, `req_bank_erase_o` and `req_part_o`. Operation code 3 completes with done and error set and issues no request.
- R2: `cfg_en_o` is 1 out of reset. It reads 0 from the cycle after a start is accepted, and it returns to 1 in the same cycle that `done_o` rises, whether or not the operation failed.
- R3: While `cfg_en_o` is 0, a command write changes nothing: the latched fields keep their values and a start bit in that write launches no operation.
- R4: Bits 27:16 give the word count. For read and program, the start address is cleared to a word boundary (WORD_BYTES, default 4), and each accepted word advances the address by WORD_BYTES. Exactly count requests are issued, and a count of 0 completes with no request and no error.
- R5: A page erase clears the address to a page boundary (default 64 bytes) and a bank erase clears it to a bank boundary (default 512 bytes). An erase issues exactly one request whatever the count.
- R6: The two program-type enables (bit 0 normal, bit 1 repair) are 1 out of reset. A write clears each bit written as 0 and never sets a bit. Starting a program of a disabled type completes with error and no request.
- R7: An erase-suspend request written while no erase is being issued reads back 0 on the next cycle. Written during an erase, it is held at 1 until `susp_ack_i` is seen.
- R8: `done_o` and `err_o` are 0 out of reset and set by hardware at completion. A status-clear write with bit 0 or bit 1 set clears done or error respectively.
- R9: A word accepted with `perm_deny_i` high ends the operation with error, and no further request is issued.
- R10: A request is held with a stable address until `req_ack_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word |
| addr_we_i | input | 1 | Start address write strobe |
| addr_wdata_i | input | ADDR_W | Byte start address |
| ptype_we_i | input | 1 | Program-type enable write strobe |
| ptype_wdata_i | input | 2 | Program-type enable data, 0 clears |
| susp_we_i | input | 1 | Erase-suspend request write strobe |
| susp_wdata_i | input | 1 | Erase-suspend request value |
| susp_ack_i | input | 1 | Downstream suspend acknowledge |
| sts_clr_we_i | input | 1 | Status clear strobe |
| sts_clr_wdata_i | input | 2 | Bit 0 clears done, bit 1 clears error |
| req_ack_i | input | 1 | Downstream accepts the current word |
| perm_deny_i | input | 1 | Permission verdict for the accepted word |
| req_o | output | 1 | Word request strobe |
| req_addr_o | output | ADDR_W | Aligned request address |
| req_op_o | output | 2 | Latched operation code |
| req_repair_o | output | 1 | Latched repair-program select |
| req_bank_erase_o | output | 1 | Latched bank-erase select |
| req_part_o | output | 1 | Latched info-partition select |
| susp_req_o | output | 1 | Erase-suspend request |
| cfg_en_o | output | 1 | Command register writable |
| done_o | output | 1 | Sticky completion flag |
| err_o | output | 1 | Sticky error flag |

## Verification
A wrong state in the sequencer shows at the ports within one or two cycles. A stuck ISSUE state keeps `req_o` high with `cfg_en_o` low, and a missed DONE state leaves `done_o` low after the last acknowledge. A miscounted word counter changes the number of strobes and the last address seen. A lock that drops too early shows as a changed `req_op_o` right after a write made while busy. A suspend latch that holds outside an erase reads back 1 one cycle after the write.

// File: rtl/fcs_pkg.sv
// Shared types for the flash command sequencer.
// Assumes a 32-bit command word with the count field at a fixed position.
package fcs_pkg;
    localparam int CNT_W   = 12;
    localparam int CNT_LSB = 16;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } state_e;

    typedef struct packed {
        op_e              op;
        logic             repair;
        logic             bank;
        logic             info;
        logic [CNT_W-1:0] count;
    } cmd_t;
endpackage

// File: rtl/fcs_cmd_regs.sv
// Command, address, program-type enable and erase-suspend registers.
// Command writes are accepted only while the sequencer is idle.
// Assumes the address and command are never written in the same cycle.
module fcs_cmd_regs
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_we_i,
    input  logic [31:0]       cmd_wdata_i,
    input  logic              addr_we_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic              ptype_we_i,
    input  logic [1:0]        ptype_wdata_i,
    input  logic              susp_we_i,
    input  logic              susp_wdata_i,
    input  logic              susp_ack_i,
    input  logic              idle_i,
    input  logic              erasing_i,
    output logic              launch_o,
    output cmd_t              cmd_next_o,
    output cmd_t              cmd_q_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [1:0]        ptype_en_o,
    output logic              susp_req_o
);
    logic cmd_take;
    logic unused_cmd_bits;

    // Decode the incoming command word into fields.
    always_comb begin
        cmd_next_o.op     = op_e'(cmd_wdata_i[5:4]);
        cmd_next_o.repair = cmd_wdata_i[6];
        cmd_next_o.bank   = cmd_wdata_i[7];
        cmd_next_o.info   = cmd_wdata_i[8];
        cmd_next_o.count  = cmd_wdata_i[CNT_LSB +: CNT_W];
    end

    assign unused_cmd_bits = ^{cmd_wdata_i[31:CNT_LSB+CNT_W], cmd_wdata_i[CNT_LSB-1:9],
                               cmd_wdata_i[3:1]};
    assign cmd_take = cmd_we_i & idle_i;
    assign launch_o = cmd_take & cmd_wdata_i[0];

    // Latch command fields while writable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cmd_q_o <= '0;
        else if (cmd_take) cmd_q_o <= cmd_next_o;
    end

    // Hold the software start address.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) addr_q_o <= '0;
        else if (addr_we_i) addr_q_o <= addr_wdata_i;
    end

    // Program-type enables that software can only clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) ptype_en_o <= 2'b11;
        else if (ptype_we_i) ptype_en_o <= ptype_en_o & ptype_wdata_i;
    end

    // Suspend request kept only while an erase is being issued.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) susp_req_o <= 1'b0;
        else susp_req_o <= erasing_i &
                           ((susp_we_i & susp_wdata_i) | (susp_req_o & ~susp_ack_i));
    end
endmodule

// File: rtl/fcs_addr_align.sv
// Clears the low address bits to the granularity of the selected operation.
// Assumes all byte sizes are powers of two.
module fcs_addr_align
    import fcs_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int WORD_BYTES     = 4,
    parameter int WORDS_PER_PAGE = 16,
    parameter int PAGES_PER_BANK = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  op_e               op_i,
    input  logic              bank_i,
    output logic [ADDR_W-1:0] aligned_o
);
    localparam int PAGE_BYTES = WORD_BYTES * WORDS_PER_PAGE;
    localparam int BANK_BYTES = PAGE_BYTES * PAGES_PER_BANK;
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(WORD_BYTES - 1);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_BYTES - 1);
    localparam logic [ADDR_W-1:0] BANK_MASK = ~ADDR_W'(BANK_BYTES - 1);

    // Pick the mask from operation kind and erase sub-type.
    always_comb begin
        if (op_i == OP_ERASE) aligned_o = addr_i & (bank_i ? BANK_MASK : PAGE_MASK);
        else                  aligned_o = addr_i & WORD_MASK;
    end
endmodule

// File: rtl/fcs_op_fsm.sv
// Operation state machine: IDLE, ISSUE (one request per word), DONE.
// Assumes the command register latches cmd_next_i on the launch edge.
module fcs_op_fsm
    import fcs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              launch_i,
    input  cmd_t              cmd_next_i,
    input  cmd_t              cmd_q_i,
    input  logic [ADDR_W-1:0] aligned_i,
    input  logic [1:0]        ptype_en_i,
    input  logic              req_ack_i,
    input  logic              perm_deny_i,
    input  logic              sts_clr_we_i,
    input  logic [1:0]        sts_clr_wdata_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              idle_o,
    output logic              erasing_o,
    output logic              done_o,
    output logic              err_o
);
    state_e           state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fail_q;
    logic             bad_cmd;
    logic             empty_cmd;
    logic             last_word;

    assign bad_cmd   = (cmd_next_i.op == OP_BAD) ||
                       ((cmd_next_i.op == OP_PROG) && !ptype_en_i[cmd_next_i.repair]);
    assign empty_cmd = (cmd_next_i.op != OP_ERASE) && (cmd_next_i.count == '0);
    assign last_word = (cmd_q_i.op == OP_ERASE) || (cnt_q == CNT_W'(1));

    assign idle_o    = (state_q == ST_IDLE);
    assign req_o     = (state_q == ST_ISSUE);
    assign erasing_o = req_o && (cmd_q_i.op == OP_ERASE);

    // Sequence the operation and step address and count per accepted word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_o  <= '0;
            fail_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (launch_i) begin
                    addr_o <= aligned_i;
                    cnt_q  <= cmd_next_i.count;
                    fail_q <= bad_cmd;
                    state_q <= (bad_cmd || empty_cmd) ? ST_DONE : ST_ISSUE;
                end
                ST_ISSUE: if (req_ack_i) begin
                    if (perm_deny_i) begin
                        fail_q  <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (last_word) begin
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q  <= cnt_q - CNT_W'(1);
                        addr_o <= addr_o + ADDR_W'(WORD_BYTES);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky completion and error flags; hardware set wins over clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= (done_o & ~(sts_clr_we_i & sts_clr_wdata_i[0])) | (state_q == ST_DONE);
            err_o  <= (err_o & ~(sts_clr_we_i & sts_clr_wdata_i[1])) |
                      ((state_q == ST_DONE) & fail_q);
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer: register front end, address
// alignment and operation state machine. Permission checks are external.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int WORD_BYTES     = 4,
    parameter int WORDS_PER_PAGE = 16,
    parameter int PAGES_PER_BANK = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_we_i,
    input  logic [31:0]       cmd_wdata_i,
    input  logic              addr_we_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic              ptype_we_i,
    input  logic [1:0]        ptype_wdata_i,
    input  logic              susp_we_i,
    input  logic              susp_wdata_i,
    input  logic              susp_ack_i,
    input  logic              sts_clr_we_i,
    input  logic [1:0]        sts_clr_wdata_i,
    input  logic              req_ack_i,
    input  logic              perm_deny_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [1:0]        req_op_o,
    output logic              req_repair_o,
    output logic              req_bank_erase_o,
    output logic              req_part_o,
    output logic              susp_req_o,
    output logic              cfg_en_o,
    output logic              done_o,
    output logic              err_o
);
    logic              launch;
    cmd_t              cmd_next;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] aligned;
    logic [1:0]        ptype_en;
    logic              idle;
    logic              erasing;
    logic              unused_cnt;

    fcs_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i, .rst_ni, .cmd_we_i, .cmd_wdata_i, .addr_we_i, .addr_wdata_i,
        .ptype_we_i, .ptype_wdata_i, .susp_we_i, .susp_wdata_i, .susp_ack_i,
        .idle_i(idle), .erasing_i(erasing), .launch_o(launch),
        .cmd_next_o(cmd_next), .cmd_q_o(cmd_q), .addr_q_o(addr_q),
        .ptype_en_o(ptype_en), .susp_req_o(susp_req_o)
    );

    fcs_addr_align #(
        .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
        .WORDS_PER_PAGE(WORDS_PER_PAGE), .PAGES_PER_BANK(PAGES_PER_BANK)
    ) u_align (
        .addr_i(addr_q), .op_i(cmd_next.op), .bank_i(cmd_next.bank), .aligned_o(aligned)
    );

    fcs_op_fsm #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_fsm (
        .clk_i, .rst_ni, .launch_i(launch), .cmd_next_i(cmd_next), .cmd_q_i(cmd_q),
        .aligned_i(aligned), .ptype_en_i(ptype_en), .req_ack_i, .perm_deny_i,
        .sts_clr_we_i, .sts_clr_wdata_i, .req_o, .addr_o(req_addr_o),
        .idle_o(idle), .erasing_o(erasing), .done_o, .err_o
    );

    assign cfg_en_o         = idle;
    assign req_op_o         = cmd_q.op;
    assign req_repair_o     = cmd_q.repair;
    assign req_bank_erase_o = cmd_q.bank;
    assign req_part_o       = cmd_q.info;
    assign unused_cnt       = ^cmd_q.count;
endmodule

// File: rtl/fcs_checker.sv
// Port-level properties of the flash command sequencer, bound to the top.
module fcs_checker #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cmd_we_i,
    input logic [31:0]       cmd_wdata_i,
    input logic              req_ack_i,
    input logic              perm_deny_i,
    input logic              req_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [1:0]        req_op_o,
    input logic              susp_req_o,
    input logic              cfg_en_o,
    input logic              done_o
);
    localparam logic [ADDR_W-1:0] LOW_BITS = ADDR_W'(WORD_BYTES - 1);

    p_bad_op_no_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_we_i && cmd_wdata_i[0] && (cmd_wdata_i[5:4] == 2'd3) && cfg_en_o |=> !req_o);

    p_busy_locks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> !cfg_en_o);

    p_done_unlocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> cfg_en_o);

    p_locked_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_we_i && !cfg_en_o |=> $stable(req_op_o));

    p_word_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o && (req_op_o != 2'd2) |-> ((req_addr_o & LOW_BITS) == '0));

    p_susp_only_erase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        susp_req_o |-> $past(req_o && (req_op_o == 2'd2)));

    p_deny_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o && req_ack_i && perm_deny_i |=> !req_o);

    p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o && !req_ack_i |=> req_o && $stable(req_addr_o));
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) i_fcs_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_wdata_i(cmd_wdata_i),
    .req_ack_i(req_ack_i), .perm_deny_i(perm_deny_i), .req_o(req_o),
    .req_addr_o(req_addr_o), .req_op_o(req_op_o), .susp_req_o(susp_req_o),
    .cfg_en_o(cfg_en_o), .done_o(done_o)
);

// File: tb/test_flash_cmd_seq.sv
// Self-checking bench: vector table walked by one loop, then directed tests.
module test_flash_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        addr_we = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic        ptype_we = 1'b0;
    logic [1:0]  ptype_wdata = '0;
    logic        susp_we = 1'b0;
    logic        susp_wdata = 1'b0;
    logic        susp_ack = 1'b0;
    logic        clr_we = 1'b0;
    logic [1:0]  clr_wdata = '0;
    logic        ack = 1'b0;
    logic        deny = 1'b0;
    logic        req, repair, bank_er, part, susp, cfg_en, done, err;
    logic [31:0] req_addr;
    logic [1:0]  req_op;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
        .addr_we_i(addr_we), .addr_wdata_i(addr_wdata), .ptype_we_i(ptype_we),
        .ptype_wdata_i(ptype_wdata), .susp_we_i(susp_we), .susp_wdata_i(susp_wdata),
        .susp_ack_i(susp_ack), .sts_clr_we_i(clr_we), .sts_clr_wdata_i(clr_wdata),
        .req_ack_i(ack), .perm_deny_i(deny), .req_o(req), .req_addr_o(req_addr),
        .req_op_o(req_op), .req_repair_o(repair), .req_bank_erase_o(bank_er),
        .req_part_o(part), .susp_req_o(susp), .cfg_en_o(cfg_en), .done_o(done), .err_o(err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] cmd;
        logic [31:0] exp_addr;
        logic [7:0]  exp_n;
        logic        exp_err;
        logic        exp_part;
    } vec_t;

    function automatic logic [31:0] mk(input logic [1:0] op, input logic rep,
                                       input logic bnk, input logic inf, input logic [11:0] n);
        return {4'h0, n, 7'h0, inf, bnk, rep, op, 3'h0, 1'b1};
    endfunction

    localparam vec_t VECS [8] = '{
        '{32'h13,    mk(2'd0, 0, 0, 0, 12'd3), 32'h10,    8'd3, 1'b0, 1'b0}, // R4 read
        '{32'h10207, mk(2'd1, 0, 0, 0, 12'd2), 32'h10204, 8'd2, 1'b0, 1'b0}, // R4 program
        '{32'h1FF,   mk(2'd2, 0, 0, 0, 12'd5), 32'h1C0,   8'd1, 1'b0, 1'b0}, // R5 page erase
        '{32'h3FF,   mk(2'd2, 0, 1, 0, 12'd0), 32'h200,   8'd1, 1'b0, 1'b0}, // R5 bank erase
        '{32'h40,    mk(2'd3, 0, 0, 0, 12'd2), 32'h0,     8'd0, 1'b1, 1'b0}, // R1 bad op
        '{32'h22,    mk(2'd0, 0, 0, 0, 12'd0), 32'h0,     8'd0, 1'b0, 1'b0}, // R4 zero count
        '{32'h8,     mk(2'd1, 1, 0, 0, 12'd1), 32'h8,     8'd1, 1'b0, 1'b0}, // R6 repair on
        '{32'h31,    mk(2'd0, 0, 0, 1, 12'd2), 32'h30,    8'd2, 1'b0, 1'b1}  // R1 info part
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_status();
        clr_we = 1'b1; clr_wdata = 2'b11;
        @(negedge clk);
        clr_we = 1'b0;
    endtask

    task automatic launch(input logic [31:0] a, input logic [31:0] c);
        addr_we = 1'b1; addr_wdata = a;
        @(negedge clk);
        addr_we = 1'b0; cmd_we = 1'b1; cmd_wdata = c;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // Acknowledge words until done, checking each request address.
    task automatic drain(input string tag, input logic [31:0] exp_addr, input logic exp_part,
                         output int n);
        n = 0;
        ack = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (req) begin
                chk({tag, " addr"}, req_addr, exp_addr + 32'(n * 4));
                chk({tag, " R1 partition"}, {31'h0, part}, {31'h0, exp_part});
                n++;
            end
            if (done) break;
            @(negedge clk);
        end
        ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk("R2 reset cfg_en", {31'h0, cfg_en}, 32'h1);
        chk("R8 reset done/err", {30'h0, done, err}, 32'h0);
        chk("R10 reset req", {31'h0, req}, 32'h0);
        chk("R7 reset susp", {31'h0, susp}, 32'h0);

        // Vector table walk.
        foreach (VECS[k]) begin
            launch(VECS[k].addr, VECS[k].cmd);
            drain($sformatf("R4/R5 vec%0d", k), VECS[k].exp_addr, VECS[k].exp_part, n);
            chk($sformatf("R4/R5 vec%0d count", k), 32'(n), {24'h0, VECS[k].exp_n});
            chk($sformatf("R8 vec%0d done", k), {31'h0, done}, 32'h1);
            chk($sformatf("R1 vec%0d err", k), {31'h0, err}, {31'h0, VECS[k].exp_err});
            chk($sformatf("R2 vec%0d unlock", k), {31'h0, cfg_en}, 32'h1);
            chk($sformatf("R1 vec%0d op", k), {30'h0, req_op}, {30'h0, VECS[k].cmd[5:4]});
            clear_status();
        end
        chk("R1 bank select latched", {31'h0, bank_er}, 32'h0);

        // R3 and R10: write during busy is ignored, request held without ack.
        launch(32'h100, mk(2'd0, 0, 0, 0, 12'd4));
        cmd_we = 1'b1; cmd_wdata = mk(2'd2, 0, 1, 0, 12'd1);
        @(negedge clk);
        cmd_we = 1'b0;
        chk("R3 op kept", {30'h0, req_op}, 32'h0);
        chk("R3 bank kept", {31'h0, bank_er}, 32'h0);
        chk("R2 locked", {31'h0, cfg_en}, 32'h0);
        chk("R10 held req", {31'h0, req}, 32'h1);
        chk("R10 held addr", req_addr, 32'h100);
        drain("R3 lock", 32'h100, 1'b0, n);
        chk("R3 words", 32'(n), 32'd4);
        repeat (3) @(negedge clk);
        chk("R3 no second op", {31'h0, req}, 32'h0);
        // R8: clear done only, error stays untouched.
        clr_we = 1'b1; clr_wdata = 2'b01;
        @(negedge clk);
        clr_we = 1'b0;
        chk("R8 done cleared", {31'h0, done}, 32'h0);

        // R9: denied first word ends the operation.
        launch(32'h200, mk(2'd0, 0, 0, 0, 12'd3));
        deny = 1'b1;
        drain("R9 deny", 32'h200, 1'b0, n);
        deny = 1'b0;
        chk("R9 words", 32'(n), 32'd1);
        chk("R9 err", {31'h0, err}, 32'h1);
        // R8: clear error only.
        clr_we = 1'b1; clr_wdata = 2'b10;
        @(negedge clk);
        clr_we = 1'b0;
        chk("R8 err cleared", {31'h0, err}, 32'h0);
        chk("R8 done kept", {31'h0, done}, 32'h1);
        clear_status();

        // R6: clear repair enable, then attempt to set it again.
        ptype_we = 1'b1; ptype_wdata = 2'b01;
        @(negedge clk);
        ptype_wdata = 2'b11;
        @(negedge clk);
        ptype_we = 1'b0;
        launch(32'h0, mk(2'd1, 1, 0, 0, 12'd2));
        drain("R6 repair off", 32'h0, 1'b0, n);
        chk("R6 no request", 32'(n), 32'd0);
        chk("R6 err", {31'h0, err}, 32'h1);
        clear_status();
        launch(32'h4, mk(2'd1, 0, 0, 0, 12'd1));
        drain("R6 normal", 32'h4, 1'b0, n);
        chk("R6 normal words", 32'(n), 32'd1);
        chk("R6 normal err", {31'h0, err}, 32'h0);
        clear_status();

        // R7: suspend while idle is dropped; during erase it is held until ack.
        susp_we = 1'b1; susp_wdata = 1'b1;
        @(negedge clk);
        susp_we = 1'b0;
        chk("R7 idle suspend dropped", {31'h0, susp}, 32'h0);
        launch(32'h47, mk(2'd2, 0, 0, 0, 12'd3));
        susp_we = 1'b1; susp_wdata = 1'b1;
        @(negedge clk);
        susp_we = 1'b0;
        chk("R7 suspend set", {31'h0, susp}, 32'h1);
        repeat (2) @(negedge clk);
        chk("R7 suspend held", {31'h0, susp}, 32'h1);
        susp_ack = 1'b1;
        @(negedge clk);
        susp_ack = 1'b0;
        chk("R7 suspend acked", {31'h0, susp}, 32'h0);
        drain("R5 erase", 32'h40, 1'b0, n);
        chk("R5 erase words", 32'(n), 32'd1);
        clear_status();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule